// File: doc/BRIEF.md
# NiMH Charge Cycle Sequencer

This block steps a series NiMH pack through one charge cycle. It never sees an analog voltage. Comparator decisions arrive as single-bit flags:

- the pack looks open;
- the cell is below the insertion level;
- the cell is above the low-battery level;
- the temperature is inside the start window;
- the temperature is over the stop limit;
- a dT/dt termination event has occurred;
- a discharge current has been sensed;
- a charge-direction current has been sensed.

Each flag is resynchronized before use. An undervoltage flag is also filtered over a programmable number of cycles. A programmed fast-charge timeout, in minutes, sets how long fast charge and top-off may last.

From these inputs the sequencer moves through eight states: reset, presence, pre-charge, fast, top-off, done, fault and discharge. In each state it drives three outputs:

- a current-reference select for the external regulation amplifier;
- a drive mode for the external pass element;
- a one-hot state code that the indicator logic decodes.

The sequencer contains its own second and minute prescaler. Presence qualification is counted in seconds. The pre-charge, fast and top-off limits are counted in minutes.

Top module: `chg_seq_top`

## Requirements
- R1: A deglitched undervoltage condition forces the reset state from any state and clears the charge timer. An undervoltage pulse shorter than DEG_CYC cycles has no effect. The undervoltage flag is active at power-up. When it clears, reset proceeds to presence.
- R2: Presence moves to pre-charge only after the below-insertion flag and the temperature-window flag have both held for QUAL_SEC consecutive seconds. Any interruption restarts that count.
- R3: Pre-charge selects the low reference (code 1) and drive mode regulate (code 2). It advances to fast charge when the above-low-battery flag is set.
- R4: Pre-charge goes to fault when PRE_MIN minutes pass without advancing, or at once when the over-temperature flag is set.
- R5: Fast charge selects the high reference (code 2) with drive mode regulate. It goes to top-off on a dT/dt event or when the programmed timeout in minutes expires. It goes to done when the over-temperature flag is set.
- R6: On entry to top-off the timer restarts from zero. Top-off selects the low reference. It goes to done when half the programmed timeout has passed, or when the over-temperature flag is set.
- R7: In pre-charge, fast, done and fault, the open-pack flag returns the block to presence.
- R8: A sensed discharge current sets a latch. While the latch is set, the block enters and stays in discharge, with reference off (code 0) and drive mode low (code 1). A sensed charge-direction current clears the latch, and the block then returns to presence.
- R9: Done and fault drive high impedance (code 0) with reference off. Each stays put until the open-pack flag is seen.
- R10: The state code is one-hot, with these bits: reset 0, presence 1, pre-charge 2, fast 3, top-off 4, done 5, fault 6, discharge 7. Exactly one bit is set after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_i | input | 1 | Supply undervoltage flag |
| cell_open_i | input | 1 | Cell voltage above open-pack level |
| cell_below_ins_i | input | 1 | Cell voltage below insertion level |
| cell_above_lb_i | input | 1 | Cell voltage above low-battery level |
| temp_win_i | input | 1 | Temperature inside start window |
| temp_over_i | input | 1 | Temperature above stop limit |
| dtdt_i | input | 1 | dT/dt termination event |
| dchg_set_i | input | 1 | Discharge current sensed |
| dchg_clr_i | input | 1 | Charge-direction current sensed |
| fast_tmo_i | input | TW | Fast-charge timeout in minutes |
| iref_sel_o | output | 2 | Reference select: 0 off, 1 low, 2 high |
| drive_o | output | 2 | Drive mode: 0 high-Z, 1 low, 2 regulate |
| state_o | output | 8 | One-hot state code |

## Verification
The bench uses a prescaler of four clocks per second and three seconds per minute, so one minute is twelve cycles. It also uses a four-second qualification and an eight-cycle undervoltage filter. With a programmed timeout of 30 minutes, the thirty-minute pre-charge and fast limits fall within a few hundred cycles, and the fifteen-minute top-off limit within fewer. Every timeout path, the qualification restart, the glitch filter and the timer clearing after undervoltage can therefore be reached and checked against cycle windows.

// File: rtl/chg_pkg.sv
package chg_pkg;
    typedef enum logic [7:0] {
        ST_RST   = 8'b0000_0001,
        ST_PRES  = 8'b0000_0010,
        ST_PRE   = 8'b0000_0100,
        ST_FAST  = 8'b0000_1000,
        ST_TOP   = 8'b0001_0000,
        ST_DONE  = 8'b0010_0000,
        ST_FAULT = 8'b0100_0000,
        ST_DISCH = 8'b1000_0000
    } state_e;

    typedef enum logic [1:0] {
        IREF_OFF  = 2'd0,
        IREF_LOW  = 2'd1,
        IREF_HIGH = 2'd2
    } iref_e;

    typedef enum logic [1:0] {
        DRV_HIZ = 2'd0,
        DRV_LOW = 2'd1,
        DRV_REG = 2'd2
    } drive_e;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[i];
                s2_q <= RST_VAL[i];
            end else begin
                s1_q <= d_i[i];
                s2_q <= s1_q;
            end
        end
        assign q_o[i] = s2_q;
    end
endmodule

// File: rtl/chg_deglitch.sv
module chg_deglitch #(
    parameter int DEG_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic filt_o
);
    localparam int CW = $clog2(DEG_CYC + 1);

    logic          filt_d, filt_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        filt_d = filt_q;
        cnt_d  = '0;
        if (in_i != filt_q) begin
            if (cnt_q == CW'(DEG_CYC - 1)) begin
                filt_d = in_i;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            filt_q <= filt_d;
            cnt_q  <= cnt_d;
        end
    end

    assign filt_o = filt_q;

    // R1
    glitch_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> filt_q == $past(in_i));
endmodule

// File: rtl/chg_prescale.sv
module chg_prescale #(
    parameter int CLK_PER_SEC = 100,
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic sec_tick_o,
    output logic min_tick_o
);
    localparam int CW = $clog2(CLK_PER_SEC + 1);
    localparam int SW = $clog2(SEC_PER_MIN + 1);

    logic [CW-1:0] cyc_d, cyc_q;
    logic [SW-1:0] sec_d, sec_q;
    logic          sec_end, min_end;

    always_comb begin
        sec_end = (cyc_q == CW'(CLK_PER_SEC - 1));
        min_end = sec_end && (sec_q == SW'(SEC_PER_MIN - 1));
        cyc_d   = sec_end ? '0 : cyc_q + 1'b1;
        sec_d   = sec_q;
        if (sec_end) sec_d = min_end ? '0 : sec_q + 1'b1;
        if (clr_i) begin
            cyc_d = '0;
            sec_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            sec_q <= '0;
        end else begin
            cyc_q <= cyc_d;
            sec_q <= sec_d;
        end
    end

    assign sec_tick_o = sec_end && !clr_i;
    assign min_tick_o = min_end && !clr_i;
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
    import chg_pkg::*;
#(
    parameter int TW       = 9,
    parameter int QUAL_SEC = 4,
    parameter int PRE_MIN  = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uvlo_i,
    input  logic          open_i,
    input  logic          below_i,
    input  logic          above_lb_i,
    input  logic          win_i,
    input  logic          over_i,
    input  logic          dtdt_i,
    input  logic          dset_i,
    input  logic          dclr_i,
    input  logic          sec_tick_i,
    input  logic          min_tick_i,
    input  logic [TW-1:0] fast_tmo_i,
    output logic          tick_clr_o,
    output state_e        state_o,
    output iref_e         iref_o,
    output drive_e        drive_o
);
    typedef struct packed {
        state_e        st;
        logic [TW-1:0] cnt;
        logic          dlat;
    } fsm_t;

    fsm_t q, d;
    logic tick;

    always_comb begin
        d          = q;
        tick_clr_o = 1'b0;
        if (dset_i)      d.dlat = 1'b1;
        else if (dclr_i) d.dlat = 1'b0;

        tick = (q.st == ST_PRES) ? sec_tick_i : min_tick_i;
        if (tick && q.cnt != '1) d.cnt = q.cnt + 1'b1;

        case (q.st)
            ST_RST:  d.st = ST_PRES;
            ST_PRES: begin
                if (!(below_i && win_i)) begin
                    d.cnt      = '0;
                    tick_clr_o = 1'b1;
                end else if (q.cnt >= TW'(QUAL_SEC)) begin
                    d.st = ST_PRE;
                end
            end
            ST_PRE: begin
                if (open_i)                      d.st = ST_PRES;
                else if (over_i)                 d.st = ST_FAULT;
                else if (above_lb_i)             d.st = ST_FAST;
                else if (q.cnt >= TW'(PRE_MIN))  d.st = ST_FAULT;
            end
            ST_FAST: begin
                if (open_i)                             d.st = ST_PRES;
                else if (over_i)                        d.st = ST_DONE;
                else if (dtdt_i || q.cnt >= fast_tmo_i) d.st = ST_TOP;
            end
            ST_TOP: begin
                if (over_i || q.cnt >= (fast_tmo_i >> 1)) d.st = ST_DONE;
            end
            ST_DONE, ST_FAULT: begin
                if (open_i) d.st = ST_PRES;
            end
            ST_DISCH: begin
                if (!q.dlat) d.st = ST_PRES;
            end
            default: d.st = ST_RST;
        endcase

        if (q.dlat && q.st != ST_DISCH) d.st = ST_DISCH;

        if (d.st != q.st) begin
            d.cnt      = '0;
            tick_clr_o = 1'b1;
        end

        if (uvlo_i) begin
            d.st       = ST_RST;
            d.cnt      = '0;
            d.dlat     = 1'b0;
            tick_clr_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_RST;
            q.cnt  <= '0;
            q.dlat <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        iref_o  = IREF_OFF;
        drive_o = DRV_HIZ;
        case (q.st)
            ST_PRE:   begin iref_o = IREF_LOW;  drive_o = DRV_REG; end
            ST_FAST:  begin iref_o = IREF_HIGH; drive_o = DRV_REG; end
            ST_TOP:   begin iref_o = IREF_LOW;  drive_o = DRV_REG; end
            ST_DISCH: begin iref_o = IREF_OFF;  drive_o = DRV_LOW; end
            default:  begin iref_o = IREF_OFF;  drive_o = DRV_HIZ; end
        endcase
    end

    assign state_o = q.st;

    // R1
    uvlo_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> q.st == ST_RST);
    // R8
    dchg_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.dlat && !uvlo_i) |=> q.st == ST_DISCH);
    // R6
    topoff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == ST_TOP) |-> q.cnt == '0);
    // R4
    fault_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FAULT && $past(q.st) != ST_FAULT) |-> $past(q.st) == ST_PRE);
    // R10
    onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.st) == 1);
endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
    import chg_pkg::*;
#(
    parameter int CLK_PER_SEC = 100_000_000,
    parameter int SEC_PER_MIN = 60,
    parameter int QUAL_SEC    = 4,
    parameter int PRE_MIN     = 30,
    parameter int MAX_MIN     = 360,
    parameter int DEG_CYC     = 1_000_000,
    localparam int TW         = $clog2(MAX_MIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uvlo_i,
    input  logic          cell_open_i,
    input  logic          cell_below_ins_i,
    input  logic          cell_above_lb_i,
    input  logic          temp_win_i,
    input  logic          temp_over_i,
    input  logic          dtdt_i,
    input  logic          dchg_set_i,
    input  logic          dchg_clr_i,
    input  logic [TW-1:0] fast_tmo_i,
    output logic [1:0]    iref_sel_o,
    output logic [1:0]    drive_o,
    output logic [7:0]    state_o
);
    localparam int NFLAG = 9;

    logic [NFLAG-1:0] raw, syn;
    logic   uvlo_f, tick_clr, sec_tick, min_tick;
    state_e st;
    iref_e  iref;
    drive_e drv;

    assign raw = {dchg_clr_i, dchg_set_i, dtdt_i, temp_over_i, temp_win_i,
                  cell_above_lb_i, cell_below_ins_i, cell_open_i, uvlo_i};

    chg_sync #(.W(NFLAG), .RST_VAL(NFLAG'(1))) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

    chg_deglitch #(.DEG_CYC(DEG_CYC)) u_deg (
        .clk(clk), .rst_n(rst_n), .in_i(syn[0]), .filt_o(uvlo_f));

    chg_prescale #(.CLK_PER_SEC(CLK_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr_i(tick_clr),
        .sec_tick_o(sec_tick), .min_tick_o(min_tick));

    chg_fsm #(.TW(TW), .QUAL_SEC(QUAL_SEC), .PRE_MIN(PRE_MIN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_f),
        .open_i(syn[1]), .below_i(syn[2]), .above_lb_i(syn[3]),
        .win_i(syn[4]), .over_i(syn[5]), .dtdt_i(syn[6]),
        .dset_i(syn[7]), .dclr_i(syn[8]),
        .sec_tick_i(sec_tick), .min_tick_i(min_tick), .fast_tmo_i(fast_tmo_i),
        .tick_clr_o(tick_clr), .state_o(st), .iref_o(iref), .drive_o(drv));

    assign iref_sel_o = iref;
    assign drive_o    = drv;
    assign state_o    = st;
endmodule

// File: tb/chg_seq_top_tb.sv
module chg_seq_top_tb;
    localparam int TW = 9;
    localparam logic [7:0] S_RST = 8'h01, S_PRES = 8'h02, S_PRE = 8'h04,
        S_FAST = 8'h08, S_TOP = 8'h10, S_DONE = 8'h20, S_FAULT = 8'h40,
        S_DISCH = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo = 1'b1, open = 1'b1, below = 1'b0, lb = 1'b0, win = 1'b0;
    logic over = 1'b0, dtdt = 1'b0, dset = 1'b0, dclr = 1'b0;
    logic [TW-1:0] tmo = 9'd30;
    logic [1:0] iref, drv;
    logic [7:0] st;
    int n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    chg_seq_top #(.CLK_PER_SEC(4), .SEC_PER_MIN(3), .QUAL_SEC(4),
                  .PRE_MIN(30), .MAX_MIN(360), .DEG_CYC(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .cell_open_i(open),
        .cell_below_ins_i(below), .cell_above_lb_i(lb), .temp_win_i(win),
        .temp_over_i(over), .dtdt_i(dtdt), .dchg_set_i(dset),
        .dchg_clr_i(dclr), .fast_tmo_i(tmo), .iref_sel_o(iref),
        .drive_o(drv), .state_o(st));

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_state(input logic [7:0] exp, input string tag);
        n_chk++;
        if (st !== exp) begin
            n_err++;
            $display("FAIL %s state act=%h exp=%h", tag, st, exp);
        end
    endtask

    task automatic chk_out(input logic [1:0] er, input logic [1:0] ed, input string tag);
        n_chk++;
        if (iref !== er || drv !== ed) begin
            n_err++;
            $display("FAIL %s iref/drive act=%0d/%0d exp=%0d/%0d", tag, iref, drv, er, ed);
        end
    endtask

    task automatic wait_state(input logic [7:0] exp, input int max, input string tag);
        int k = 0;
        while (st !== exp && k < max) begin
            cyc(1);
            k++;
        end
        chk_state(exp, tag);
    endtask

    task automatic go_pre();
        open = 0; below = 1; win = 1; lb = 0; over = 0;
        wait_state(S_PRES, 40, "R7 via presence");
        wait_state(S_PRE, 40, "R2 qualify");
    endtask

    task automatic go_fast();
        go_pre();
        lb = 1;
        wait_state(S_FAST, 8, "R3 advance");
    endtask

    task automatic unplug();
        open = 1; below = 0; lb = 0; over = 0;
        wait_state(S_PRES, 10, "R7 open");
    endtask

    task automatic t_reset();
        cyc(1);
        chk_state(S_RST, "R1 reset state");
        chk_out(2'd0, 2'd0, "R1 reset outputs");
        n_chk++;
        if ($countones(st) != 1) begin
            n_err++;
            $display("FAIL R10 onehot act=%h exp=one bit", st);
        end
        cyc(20);
        chk_state(S_RST, "R1 held by uvlo");
        uvlo = 0;
        wait_state(S_PRES, 30, "R1 release");
    endtask

    task automatic t_qual();
        open = 0; below = 1; win = 1;
        cyc(8);
        chk_state(S_PRES, "R2 not yet");
        win = 0; cyc(4); win = 1;
        cyc(14);
        chk_state(S_PRES, "R2 restart");
        wait_state(S_PRE, 20, "R2 qualified");
        chk_out(2'd1, 2'd2, "R3 precharge outputs");
    endtask

    task automatic t_pre_timeout();
        cyc(345);
        chk_state(S_PRE, "R4 before timeout");
        wait_state(S_FAULT, 40, "R4 timeout");
        chk_out(2'd0, 2'd0, "R9 fault outputs");
        cyc(40);
        chk_state(S_FAULT, "R9 fault holds");
        unplug();
    endtask

    task automatic t_dtdt_topoff();
        go_fast();
        chk_out(2'd2, 2'd2, "R5 fast outputs");
        dtdt = 1; cyc(2); dtdt = 0;
        wait_state(S_TOP, 8, "R5 dtdt");
        chk_out(2'd1, 2'd2, "R6 topoff outputs");
        cyc(170);
        chk_state(S_TOP, "R6 half timeout not yet");
        wait_state(S_DONE, 30, "R6 half timeout");
        chk_out(2'd0, 2'd0, "R9 done outputs");
        cyc(30);
        chk_state(S_DONE, "R9 done holds");
        unplug();
    endtask

    task automatic t_fast_timeout();
        go_fast();
        cyc(350);
        chk_state(S_FAST, "R5 before timeout");
        wait_state(S_TOP, 25, "R5 timeout");
        over = 1;
        wait_state(S_DONE, 8, "R6 overtemp");
        unplug();
    endtask

    task automatic t_temp();
        go_pre();
        over = 1;
        wait_state(S_FAULT, 8, "R4 overtemp");
        unplug();
        go_fast();
        over = 1;
        wait_state(S_DONE, 8, "R5 overtemp");
        unplug();
        go_fast();
        unplug();
    endtask

    task automatic t_dchg();
        go_fast();
        dset = 1; cyc(2); dset = 0;
        wait_state(S_DISCH, 8, "R8 enter");
        chk_out(2'd0, 2'd1, "R8 outputs");
        lb = 0;
        cyc(20);
        chk_state(S_DISCH, "R8 latched");
        dclr = 1; cyc(2); dclr = 0;
        wait_state(S_PRES, 8, "R8 leave");
    endtask

    task automatic t_uvlo();
        go_pre();
        cyc(300);
        uvlo = 1; cyc(3); uvlo = 0;
        cyc(15);
        chk_state(S_PRE, "R1 glitch ignored");
        uvlo = 1;
        wait_state(S_RST, 20, "R1 forced reset");
        chk_out(2'd0, 2'd0, "R1 reset outputs");
        uvlo = 0;
        wait_state(S_PRES, 30, "R1 release");
        wait_state(S_PRE, 40, "R2 requalify");
        cyc(345);
        chk_state(S_PRE, "R1 timer cleared");
    endtask

    initial begin
        cyc(5);
        rst_n = 1;
        t_reset();
        t_qual();
        t_pre_timeout();
        t_dtdt_topoff();
        t_fast_timeout();
        t_temp();
        t_dchg();
        t_uvlo();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule